// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Stored Flags and Branch Decision

This block is the execute-stage arithmetic unit of a simple sequential processor. It combines two 32-bit operands under a 4-bit function code and drives the result combinationally. The second operand is the left-hand side of every operation, so a subtract produces `op_b - op_a`. The same unit also serves address arithmetic, such as base plus displacement or stack pointer plus four, by selecting the add function.

Three status flags are kept in a small register: zero, sign and signed overflow. They load on a rising clock edge only while `flag_wr` is high. The surrounding control raises `flag_wr` for arithmetic/logical instructions and keeps it low for address computations. A combinational decoder compares the stored flags against a 4-bit condition code and reports whether a conditional transfer is taken.

Top module: `alu_cc_unit`

## Requirements
- R1: With `alu_fn` = 0, `result` equals `op_b + op_a` modulo 2^32, in the same cycle.
- R2: With `alu_fn` = 1, `result` equals `op_b - op_a` modulo 2^32. The operand order is fixed: `op_b` is the minuend.
- R3: With `alu_fn` = 2, `result` is the bitwise AND of the operands. With `alu_fn` = 3, it is their bitwise XOR.
- R4: Any `alu_fn` from 4 to 15 gives `result` = 0.
- R5: The flags take new values only at a rising `clk` edge where `flag_wr` = 1. At any other edge they keep their previous values, whatever the operands or function are.
- R6: When loaded, the zero flag is 1 exactly when `result` is 0, and the sign flag copies `result[31]`.
- R7: When loaded, the overflow flag is the signed overflow of the add (R1) or subtract (R2). It is 0 for AND, XOR and the unused function codes.
- R8: While `rst_n` is low, and after it is released until the first load, the flags are zero = 1, sign = 0, overflow = 0.
- R9: `take_branch` follows `cond_fn` and the stored flags (Z, S, O) combinationally: 0 gives 1; 1 gives (S^O)|Z; 2 gives S^O; 3 gives Z; 4 gives !Z; 5 gives !(S^O); 6 gives !(S^O)&!Z.
- R10: `cond_fn` values 7 to 15 give `take_branch` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flags load on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| op_a | input | 32 | Right-hand operand |
| op_b | input | 32 | Left-hand operand |
| alu_fn | input | 4 | Operation select: 0 add, 1 subtract, 2 AND, 3 XOR |
| flag_wr | input | 1 | Load the flags from this cycle's result |
| cond_fn | input | 4 | Branch condition select, 0 to 6 |
| result | output | 32 | Combinational operation result |
| take_branch | output | 1 | Branch decision from the stored flags |

## Verification
A wrong flag is not visible on `result`. It shows only through `take_branch`, starting the cycle after the edge that loaded it, and only for condition codes that depend on that flag. For this reason each flag update is followed by a sweep of all sixteen condition codes, which separates Z, S and O from one another. A load that should not have happened, or a missed load, appears one edge later as a changed or unchanged decision under conditions 2 to 6. A wrong operand order appears at once on `result` for any subtract with unequal operands.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

  typedef enum logic [3:0] {
    FN_ADD = 4'd0,
    FN_SUB = 4'd1,
    FN_AND = 4'd2,
    FN_XOR = 4'd3
  } alu_fn_e;

  typedef enum logic [3:0] {
    CD_ALWAYS = 4'd0,
    CD_LE     = 4'd1,
    CD_LT     = 4'd2,
    CD_EQ     = 4'd3,
    CD_NE     = 4'd4,
    CD_GE     = 4'd5,
    CD_GT     = 4'd6
  } cond_e;

  typedef struct packed {
    logic zf;
    logic sf;
    logic of;
  } cc_flags_t;

  localparam cc_flags_t CC_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};

endpackage

// File: rtl/alu_core.sv
module alu_core
  import alu_cc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [3:0]   fn,
  output logic [W-1:0] res,
  output cc_flags_t    flags_new
);
  localparam int MSB = W - 1;

  logic [W-1:0] sum_v;
  logic [W-1:0] diff_v;
  logic         add_ovf;
  logic         sub_ovf;

  always_comb begin
    sum_v  = op_b + op_a;
    diff_v = op_b - op_a;
    add_ovf = (op_a[MSB] == op_b[MSB]) && (sum_v[MSB]  != op_b[MSB]);
    sub_ovf = (op_a[MSB] != op_b[MSB]) && (diff_v[MSB] != op_b[MSB]);
  end

  always_comb begin
    res          = '0;
    flags_new.of = 1'b0;
    case (fn)
      FN_ADD: begin
        res          = sum_v;
        flags_new.of = add_ovf;
      end
      FN_SUB: begin
        res          = diff_v;
        flags_new.of = sub_ovf;
      end
      FN_AND:  res = op_b & op_a;
      FN_XOR:  res = op_b ^ op_a;
      default: res = '0;
    endcase
    flags_new.zf = (res == '0);
    flags_new.sf = res[MSB];
  end

endmodule

// File: rtl/cc_reg.sv
module cc_reg
  import alu_cc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load_en,
  input  cc_flags_t d,
  output cc_flags_t q
);
  cc_flags_t q_nxt;

  always_comb begin
    q_nxt = q;
    if (load_en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= CC_RESET;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/branch_eval.sv
module branch_eval
  import alu_cc_pkg::*;
(
  input  cc_flags_t  flags,
  input  logic [3:0] cond,
  output logic       taken
);
  logic lt;

  always_comb begin
    lt = flags.sf ^ flags.of;
    case (cond)
      CD_ALWAYS: taken = 1'b1;
      CD_LE:     taken = lt | flags.zf;
      CD_LT:     taken = lt;
      CD_EQ:     taken = flags.zf;
      CD_NE:     taken = ~flags.zf;
      CD_GE:     taken = ~lt;
      CD_GT:     taken = ~lt & ~flags.zf;
      default:   taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
  import alu_cc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [3:0]   alu_fn,
  input  logic         flag_wr,
  input  logic [3:0]   cond_fn,
  output logic [W-1:0] result,
  output logic         take_branch
);
  cc_flags_t flags_new;
  cc_flags_t flags_q;

  alu_core #(.W(W)) u_core (
    .op_a      (op_a),
    .op_b      (op_b),
    .fn        (alu_fn),
    .res       (result),
    .flags_new (flags_new)
  );

  cc_reg u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (flag_wr),
    .d       (flags_new),
    .q       (flags_q)
  );

  branch_eval u_branch (
    .flags (flags_q),
    .cond  (cond_fn),
    .taken (take_branch)
  );

endmodule

// File: rtl/alu_cc_unit_chk.sv
module alu_cc_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [3:0]   alu_fn,
  input logic         flag_wr,
  input logic [3:0]   cond_fn,
  input logic [W-1:0] result,
  input logic         take_branch
);
  logic [W-1:0] sum_chk;
  logic [W-1:0] diff_chk;
  assign sum_chk  = op_b + op_a;
  assign diff_chk = op_b - op_a;

  a_r1_add_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_fn == 4'd0) |-> (result == sum_chk));

  a_r2_sub_order: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_fn == 4'd1) |-> (result == diff_chk));

  a_r5_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!flag_wr) && $stable(cond_fn)) |-> $stable(take_branch));

  a_r6_zero_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && result == '0) |=> (cond_fn != 4'd3 || take_branch));

  a_r7_logic_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && (alu_fn == 4'd2 || alu_fn == 4'd3))
      |=> (cond_fn != 4'd2 || take_branch == $past(result[W-1])));

  a_r9_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_fn == 4'd0) |-> take_branch);

  a_r10_unused_cond: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_fn > 4'd6) |-> !take_branch);

endmodule

bind alu_cc_unit alu_cc_unit_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_a        (op_a),
  .op_b        (op_b),
  .alu_fn      (alu_fn),
  .flag_wr     (flag_wr),
  .cond_fn     (cond_fn),
  .result      (result),
  .take_branch (take_branch)
);

// File: tb/alu_cc_unit_test.sv
`timescale 1ns/1ps
module alu_cc_unit_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [3:0]   alu_fn = '0;
  logic         flag_wr = 1'b0;
  logic [3:0]   cond_fn = '0;
  logic [W-1:0] result;
  logic         take_branch;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic mz = 1'b1, ms = 1'b0, mo = 1'b0;

  always #5 clk = ~clk;

  alu_cc_unit #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .alu_fn(alu_fn),
    .flag_wr(flag_wr), .cond_fn(cond_fn), .result(result), .take_branch(take_branch)
  );

  task automatic chk(input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] m_res(input logic [3:0] f, input logic [W-1:0] a,
                                         input logic [W-1:0] b);
    case (f)
      4'd0: return b + a;
      4'd1: return b - a;
      4'd2: return b & a;
      4'd3: return b ^ a;
      default: return '0;
    endcase
  endfunction

  function automatic logic m_take(input int c, input logic z, input logic s, input logic o);
    case (c)
      0: return 1'b1;
      1: return (s ^ o) | z;
      2: return s ^ o;
      3: return z;
      4: return !z;
      5: return !(s ^ o);
      6: return !(s ^ o) && !z;
      default: return 1'b0;
    endcase
  endfunction

  // sweep all condition codes against the model flags (R9, R10)
  task automatic probe(input string req);
    for (int c = 0; c < 16; c++) begin
      cond_fn = 4'(c);
      #1;
      chk(req, $sformatf("cond=%0d", c), W'(take_branch), W'(m_take(c, mz, ms, mo)));
    end
  endtask

  task automatic apply(input logic [3:0] f, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic wr, input string rreq, input string freq);
    logic [W-1:0] r;
    @(negedge clk);
    alu_fn = f; op_a = a; op_b = b; flag_wr = wr;
    #1;
    r = m_res(f, a, b);
    chk(rreq, $sformatf("fn=%0d result", f), result, r);
    @(posedge clk);
    #1;
    flag_wr = 1'b0;
    if (wr) begin
      mz = (r == '0);
      ms = r[W-1];
      if (f == 4'd0)      mo = (a[W-1] == b[W-1]) && (r[W-1] != b[W-1]);
      else if (f == 4'd1) mo = (a[W-1] != b[W-1]) && (r[W-1] != b[W-1]);
      else                mo = 1'b0;
    end
    probe(freq);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    #12;
    probe("R8 during reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    probe("R8 after release");
  endtask

  task automatic t_add;
    apply(4'd0, 32'd7, 32'd5, 1'b1, "R1", "R6");
    apply(4'd0, 32'd1, 32'h7fff_ffff, 1'b1, "R1", "R7 add ovf");
    apply(4'd0, 32'd1, 32'hffff_ffff, 1'b1, "R1", "R6 wrap zero");
    apply(4'd0, 32'h8000_0000, 32'h8000_0000, 1'b1, "R1", "R7 neg ovf");
  endtask

  task automatic t_sub;
    apply(4'd1, 32'd5, 32'd5, 1'b1, "R2", "R6 equal");
    apply(4'd1, 32'd9, 32'd3, 1'b1, "R2 order", "R6 negative");
    apply(4'd1, 32'd1, 32'h8000_0000, 1'b1, "R2", "R7 sub ovf");
    apply(4'd1, 32'd3, 32'd9, 1'b1, "R2 order", "R9 greater");
  endtask

  task automatic t_logic;
    apply(4'd0, 32'd1, 32'h7fff_ffff, 1'b1, "R1", "R7 set");
    apply(4'd2, 32'hf0f0_0000, 32'hff00_ff00, 1'b1, "R3 and", "R7 cleared");
    apply(4'd3, 32'h1234_5678, 32'h1234_5678, 1'b1, "R3 xor", "R6 xor zero");
    apply(4'd3, 32'h0000_ffff, 32'h0f0f_0f0f, 1'b1, "R3 xor", "R7 cleared");
  endtask

  task automatic t_undef;
    apply(4'd0, 32'd1, 32'h7fff_ffff, 1'b1, "R1", "R7 set");
    apply(4'd9, 32'hdead_beef, 32'h1234_5678, 1'b1, "R4", "R7 unused fn");
    apply(4'd15, 32'h1, 32'h2, 1'b0, "R4", "R5");
  endtask

  task automatic t_hold;
    apply(4'd1, 32'd9, 32'd3, 1'b1, "R2", "R6 negative");
    apply(4'd1, 32'd4, 32'd4, 1'b0, "R2", "R5 hold after zero op");
    apply(4'd0, 32'd1, 32'h7fff_ffff, 1'b0, "R1", "R5 hold after ovf op");
  endtask

  task automatic t_midreset;
    apply(4'd1, 32'd9, 32'd3, 1'b1, "R2", "R6");
    @(negedge clk);
    rst_n = 1'b0;
    mz = 1'b1; ms = 1'b0; mo = 1'b0;
    #2;
    probe("R8 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    probe("R8 released");
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_undef();
    t_hold();
    t_midreset();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule